// File: doc/BRIEF.md
# Load, Immediate and Stack Data Formatter

This block sits between a processor's register file and its data memory and shapes the data that moves between them. It takes one command at a time. A command carries an operation class, a width code, an embedded byte and two register values: an address and a data word. The block then runs one of three kinds of work:

- Loads and pops read data memory. The result is sized to one of four widths and filled out to the full register, either with sign extension or with zeros.
- Immediates take a byte from the command itself, or collect 16-bit program words that trail the instruction.
- Stores and pushes write a register to data memory. Push and pop also return the stepped stack address.

Data memory is byte-addressed and little-endian. Byte `k` of a request or response lane belongs to address `addr + k`.

The command input, the program-word input and the memory request output use valid/ready handshakes:

- A transfer happens on a clock edge where valid and ready are both high.
- `cmd_ready` is high only while the block is idle.
- `pw_ready` is high only while immediate words are still owed.
- Once `mem_valid` rises, the request stays unchanged until `mem_ready` accepts it.
- The memory response has no ready. It is taken only while a read is outstanding.
- `rf_we` and `addr_we` are plain one-cycle strobes.

Operation codes are listed in R2, R4, R5, R6, R7 and R8. Code 7 is reserved: it is accepted and completes with no memory access and no register write.

Top module: `ldst_fmt`

## Requirements
- R1: Out of reset and whenever no command is in progress, `cmd_ready` is 1, `busy` is 0, and `rf_we`, `addr_we`, `mem_valid` and `pw_ready` are 0. `busy` is always the inverse of `cmd_ready`.
- R2: Op 0 (signed load) and op 1 (unsigned load) read at `cmd_addr`. The result keeps the low `cmd_wid`+1 bytes of `rsp_data` (width codes 0..3 mean 8, 16, 24, 32 bits). Op 0 copies the top kept bit into all higher bits; op 1 clears them.
- R3: A load result appears on `rf_wdata` with `rf_we` high in the cycle after the cycle in which `rsp_valid` was taken.
- R4: Op 2 (signed immediate) and op 3 (unsigned immediate) with width code 0 take the value from `cmd_imm8`, filled out as in R2. No program word is requested. `rf_we` is high in the cycle after the command is accepted.
- R5: Immediates with width code 1, 2 or 3 take one, two and two program words. The first word is the low 16 bits. Bits above the width are ignored. `pw_ready` and `busy` stay high until the last word is taken, and `rf_we` follows in the next cycle.
- R6: Op 4 (store) issues one write at `cmd_addr` with `mem_wdata` = `cmd_data`. `mem_be` bits 0..`cmd_wid` are set and the rest are clear. A store raises neither `rf_we` nor `addr_we`.
- R7: Op 5 (push) writes all four bytes of `cmd_data` at `cmd_addr`. In the cycle after the write is accepted, it raises `addr_we` with `addr_out` = `cmd_addr`+4 and leaves `rf_we` low.
- R8: Op 6 (pop) reads four bytes at `cmd_addr`-4. In one cycle it then raises `rf_we` with the full word and `addr_we` with `addr_out` = `cmd_addr`-4.
- R9: While `mem_valid` is high and `mem_ready` is low, the request holds: `mem_valid`, `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` stay the same in the next cycle.
- R10: `rsp_valid` has no effect while no read is outstanding, and `cmd_ready` stays low while a request is stalled.
- R11: `rf_we` and `addr_we` are never high in two consecutive cycles, and each command raises each strobe at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on handshake |
| cmd_op | input | 3 | Operation class code |
| cmd_wid | input | 2 | Width code, bytes minus one |
| cmd_imm8 | input | 8 | Byte constant embedded in the instruction |
| cmd_addr | input | 32 | Address register value |
| cmd_data | input | 32 | Data register value for store and push |
| busy | output | 1 | Command in progress |
| pw_valid | input | 1 | Trailing program word offered |
| pw_ready | output | 1 | Immediate word wanted |
| pw_data | input | 16 | Trailing program word |
| mem_valid | output | 1 | Data memory request |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of request |
| mem_be | output | 4 | Byte lanes in use |
| mem_wdata | output | 32 | Write data, lane k at address+k |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 32 | Read data, lane k at address+k |
| rf_we | output | 1 | Register write strobe |
| rf_wdata | output | 32 | Register write value |
| addr_we | output | 1 | Stack address update strobe |
| addr_out | output | 32 | Stepped stack address |

## Verification
A wrong width or fill selection shows as a bad `rf_wdata` value on the single strobe that ends the command. That happens one cycle after the response, the last program word, or the embedded byte. A word counter that stops too early or runs too long shows as a missing or extra `pw_ready` cycle, or as the wrong half of an immediate. A misstepped stack pointer shows on `mem_addr` while the request is pending, and on `addr_out` at the end of the same command. A state machine that leaves its idle state wrongly or holds a state too long shows as a doubled strobe, or as a `cmd_ready` that returns late or early, before the next command can begin.

// File: rtl/ldst_fmt_pkg.sv
package ldst_fmt_pkg;

  typedef enum logic [2:0] {
    OP_LD_SX  = 3'd0,
    OP_LD_ZX  = 3'd1,
    OP_IMM_SX = 3'd2,
    OP_IMM_ZX = 3'd3,
    OP_STORE  = 3'd4,
    OP_PUSH   = 3'd5,
    OP_POP    = 3'd6,
    OP_RSVD   = 3'd7
  } fmt_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IMM,
    ST_REQ,
    ST_RSP,
    ST_WB
  } fmt_state_e;

  function automatic logic op_is_imm(fmt_op_e op);
    return (op == OP_IMM_SX) || (op == OP_IMM_ZX);
  endfunction

  function automatic logic op_is_read(fmt_op_e op);
    return (op == OP_LD_SX) || (op == OP_LD_ZX) || (op == OP_POP);
  endfunction

  function automatic logic op_sign(fmt_op_e op);
    return (op == OP_LD_SX) || (op == OP_IMM_SX);
  endfunction

endpackage

// File: rtl/ldst_fmt_ext.sv
module ldst_fmt_ext #(
  parameter int DW  = 32,
  parameter int WCW = 2
) (
  input  logic [DW-1:0]  raw,
  input  logic [WCW-1:0] wid,
  input  logic           sx,
  output logic [DW-1:0]  val
);
  localparam int NW = DW / 8;

  logic [DW-1:0] cand [NW];

  for (genvar k = 0; k < NW; k++) begin : g_wid
    localparam int NB = 8 * (k + 1);
    if (NB == DW) begin : g_full
      assign cand[k] = raw;
    end else begin : g_part
      assign cand[k] = {{(DW-NB){sx & raw[NB-1]}}, raw[NB-1:0]};
    end
  end

  always_comb begin
    val = cand[0];
    for (int k = 0; k < NW; k++) begin
      if (wid == WCW'(k)) val = cand[k];
    end
  end
endmodule

// File: rtl/ldst_fmt_immcol.sv
module ldst_fmt_immcol #(
  parameter int DW = 32,
  parameter int PW = 16,
  localparam int MAXW = (DW + PW - 1) / PW,
  localparam int IW = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          take,
  input  logic [PW-1:0] word,
  input  logic [IW-1:0] need_m1,
  output logic          last,
  output logic [DW-1:0] value
);
  logic [PW-1:0]      wq [MAXW];
  logic [IW-1:0]      idx;
  logic [MAXW*PW-1:0] flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      for (int k = 0; k < MAXW; k++) wq[k] <= '0;
    end else if (start) begin
      idx <= '0;
      for (int k = 0; k < MAXW; k++) wq[k] <= '0;
    end else if (take) begin
      idx <= idx + IW'(1);
      for (int k = 0; k < MAXW; k++) begin
        if (idx == IW'(k)) wq[k] <= word;
      end
    end
  end

  for (genvar k = 0; k < MAXW; k++) begin : g_flat
    assign flat[k*PW +: PW] = wq[k];
  end

  assign value = flat[DW-1:0];
  assign last  = take && (idx == need_m1);
endmodule

// File: rtl/ldst_fmt_req.sv
module ldst_fmt_req
  import ldst_fmt_pkg::*;
#(
  parameter int DW  = 32,
  parameter int WCW = 2,
  localparam int NBY = DW / 8
) (
  input  fmt_op_e        op,
  input  logic [WCW-1:0] wid,
  input  logic [DW-1:0]  base,
  input  logic [DW-1:0]  data,
  output logic           we,
  output logic [DW-1:0]  addr,
  output logic [NBY-1:0] be,
  output logic [DW-1:0]  wdata,
  output logic [DW-1:0]  step
);
  logic [DW-1:0] up, down;

  assign up    = base + DW'(NBY);
  assign down  = base - DW'(NBY);
  assign we    = (op == OP_STORE) || (op == OP_PUSH);
  assign addr  = (op == OP_POP) ? down : base;
  assign step  = (op == OP_POP) ? down : up;
  assign wdata = data;

  always_comb begin
    be = '0;
    for (int k = 0; k < NBY; k++) begin
      if ((op == OP_PUSH) || (op == OP_POP) || (k <= int'(wid))) be[k] = 1'b1;
    end
  end
endmodule

// File: rtl/ldst_fmt.sv
module ldst_fmt
  import ldst_fmt_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 16,
  localparam int NBY = DW / 8,
  localparam int WCW = $clog2(NBY),
  localparam int MAXW = (DW + PW - 1) / PW,
  localparam int IW = $clog2(MAXW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [WCW-1:0] cmd_wid,
  input  logic [7:0]     cmd_imm8,
  input  logic [DW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_data,
  output logic           busy,
  input  logic           pw_valid,
  output logic           pw_ready,
  input  logic [PW-1:0]  pw_data,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [NBY-1:0] mem_be,
  output logic [DW-1:0]  mem_wdata,
  input  logic           rsp_valid,
  input  logic [DW-1:0]  rsp_data,
  output logic           rf_we,
  output logic [DW-1:0]  rf_wdata,
  output logic           addr_we,
  output logic [DW-1:0]  addr_out
);
  fmt_state_e     state, state_d;
  fmt_op_e        op_q, cmd_op_e;
  logic [WCW-1:0] wid_q, wid_eff;
  logic [DW-1:0]  base_q, data_q, raw_q, col_val, ext_src;
  logic [IW-1:0]  need_m1;
  logic           acc, col_last, take;

  assign cmd_op_e  = fmt_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign busy      = ~cmd_ready;
  assign acc       = cmd_valid && cmd_ready;
  assign pw_ready  = (state == ST_IMM);
  assign mem_valid = (state == ST_REQ);
  assign take      = pw_ready && pw_valid;

  // words owed for a wide immediate: ceil(bytes*8/PW), minus one
  always_comb begin
    int nb;
    int nw;
    nb      = int'(wid_q) + 1;
    nw      = (nb * 8 + PW - 1) / PW;
    need_m1 = IW'(nw - 1);
  end

  ldst_fmt_immcol #(.DW(DW), .PW(PW)) u_col (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (acc),
    .take   (take),
    .word   (pw_data),
    .need_m1(need_m1),
    .last   (col_last),
    .value  (col_val)
  );

  ldst_fmt_req #(.DW(DW), .WCW(WCW)) u_req (
    .op   (op_q),
    .wid  (wid_q),
    .base (base_q),
    .data (data_q),
    .we   (mem_we),
    .addr (mem_addr),
    .be   (mem_be),
    .wdata(mem_wdata),
    .step (addr_out)
  );

  assign ext_src = (op_is_imm(op_q) && (wid_q != '0)) ? col_val : raw_q;
  assign wid_eff = (op_q == OP_POP) ? WCW'(NBY - 1) : wid_q;

  ldst_fmt_ext #(.DW(DW), .WCW(WCW)) u_ext (
    .raw(ext_src),
    .wid(wid_eff),
    .sx (op_sign(op_q)),
    .val(rf_wdata)
  );

  assign rf_we   = (state == ST_WB) && (op_is_read(op_q) || op_is_imm(op_q));
  assign addr_we = (state == ST_WB) && ((op_q == OP_PUSH) || (op_q == OP_POP));

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (acc) begin
          if (op_is_imm(cmd_op_e))       state_d = (cmd_wid == '0) ? ST_WB : ST_IMM;
          else if (cmd_op_e == OP_RSVD)  state_d = ST_IDLE;
          else                           state_d = ST_REQ;
        end
      end
      ST_IMM:  if (col_last) state_d = ST_WB;
      ST_REQ: begin
        if (mem_ready) begin
          if (op_is_read(op_q))        state_d = ST_RSP;
          else if (op_q == OP_PUSH)    state_d = ST_WB;
          else                         state_d = ST_IDLE;
        end
      end
      ST_RSP:  if (rsp_valid) state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_RSVD;
      wid_q  <= '0;
      base_q <= '0;
      data_q <= '0;
      raw_q  <= '0;
    end else begin
      state <= state_d;
      if (acc) begin
        op_q   <= cmd_op_e;
        wid_q  <= cmd_wid;
        base_q <= cmd_addr;
        data_q <= cmd_data;
        raw_q  <= DW'(cmd_imm8);
      end else if ((state == ST_RSP) && rsp_valid) begin
        raw_q <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/ldst_fmt_chk.sv
module ldst_fmt_chk #(
  parameter int DW = 32,
  parameter int PW = 16,
  localparam int NBY = DW / 8,
  localparam int WCW = $clog2(NBY)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic           busy,
  input logic           pw_valid,
  input logic           pw_ready,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [DW-1:0]  mem_addr,
  input logic [NBY-1:0] mem_be,
  input logic [DW-1:0]  mem_wdata,
  input logic           rsp_valid,
  input logic           rf_we,
  input logic           addr_we,
  input logic [DW-1:0]  addr_out
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (!cmd_ready && !pw_ready && busy));

  // R3
  wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(rsp_valid || (pw_valid && pw_ready) || (cmd_valid && cmd_ready)));

  // R5
  imm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_ready |-> (busy && !rf_we && !mem_valid));

  // R6
  be_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be[0] && ((mem_be & (mem_be + NBY'(1))) == '0)));

  // R7
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && !rf_we) |-> ($past(mem_valid && mem_ready && mem_we) &&
                             (addr_out == $past(mem_addr) + DW'(NBY))));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr) &&
                                   $stable(mem_be) && $stable(mem_wdata)));

  // R11
  rf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R11
  addr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> !addr_we);
endmodule

bind ldst_fmt ldst_fmt_chk #(.DW(DW), .PW(PW)) u_chk (.*);

// File: tb/sim_ldst_fmt.sv
`timescale 1ns/1ps
module sim_ldst_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_wid = '0;
  logic [7:0]  cmd_imm8 = '0;
  logic [31:0] cmd_addr = '0, cmd_data = '0;
  logic        busy;
  logic        pw_valid = 1'b0, pw_ready;
  logic [15:0] pw_data = '0;
  logic        mem_valid, mem_ready = 1'b1, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rf_we, addr_we;
  logic [31:0] rf_wdata, addr_out;

  always #5 clk = ~clk;

  ldst_fmt u0 (.*);

  int nchk = 0, nfail = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model
  logic [7:0]  mem [256];
  int          stall_left = 0;
  logic        pend = 1'b0, stray = 1'b0;
  logic [31:0] pend_d = '0;

  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = pend;
      rsp_data  = pend_d;
      pend      = 1'b0;
      if (stray) begin
        rsp_valid = 1'b1;
        rsp_data  = 32'hFFFF_FFFF;
        stray     = 1'b0;
      end
      mem_ready = (stall_left == 0);
      if (mem_valid && !mem_ready) stall_left--;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[8'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
        end else begin
          pend = 1'b1;
          for (int k = 0; k < 4; k++) pend_d[8*k +: 8] = mem[8'(mem_addr + 32'(k))];
        end
      end
    end
  end

  // observations of one command
  logic [31:0] got_rf, got_ad;
  int n_rf, n_ad, req_cyc, gap_busy, rdy_stall;
  logic addr_bad, dbl, done;

  task automatic run_cmd(input logic [2:0] op, input logic [1:0] wid, input logic [31:0] addr,
                         input logic [31:0] data, input logic [31:0] src, input int gap,
                         input logic [31:0] exp_maddr);
    int pi;
    int g;
    logic prev_rf, prev_ad;
    @(negedge clk);
    cmd_op = op; cmd_wid = wid; cmd_addr = addr; cmd_data = data; cmd_imm8 = src[7:0];
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n_rf = 0; n_ad = 0; req_cyc = 0; gap_busy = 0; rdy_stall = 0;
    addr_bad = 1'b0; dbl = 1'b0; done = 1'b0; prev_rf = 1'b0; prev_ad = 1'b0;
    pi = 0; g = gap;
    for (int c = 0; c < 60; c++) begin
      pw_valid = 1'b0;
      if (rf_we) begin got_rf = rf_wdata; n_rf++; end
      if (addr_we) begin got_ad = addr_out; n_ad++; end
      if ((rf_we && prev_rf) || (addr_we && prev_ad)) dbl = 1'b1;
      prev_rf = rf_we; prev_ad = addr_we;
      if (mem_valid) begin
        req_cyc++;
        if (mem_addr != exp_maddr) addr_bad = 1'b1;
        if (cmd_ready) rdy_stall++;
      end
      if (pw_ready) begin
        if (g > 0) begin
          g--;
          if (busy && !rf_we) gap_busy++;
        end else begin
          pw_valid = 1'b1;
          pw_data  = (pi == 0) ? src[15:0] : src[31:16];
          pi++;
        end
      end
      if (cmd_ready) begin done = 1'b1; break; end
      @(negedge clk);
    end
    pw_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  wid;
    logic [31:0] src;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{3'd0, 2'd0, 32'h0000_00A5, 32'hFFFF_FFA5},
    '{3'd1, 2'd0, 32'h0000_00A5, 32'h0000_00A5},
    '{3'd0, 2'd1, 32'h0000_7F80, 32'h0000_7F80},
    '{3'd0, 2'd1, 32'h1234_C001, 32'hFFFF_C001},
    '{3'd1, 2'd1, 32'hFFFF_8001, 32'h0000_8001},
    '{3'd0, 2'd2, 32'h0080_0000, 32'hFF80_0000},
    '{3'd1, 2'd2, 32'hAA92_3456, 32'h0092_3456},
    '{3'd0, 2'd3, 32'h8000_0001, 32'h8000_0001},
    '{3'd2, 2'd0, 32'h0000_0080, 32'hFFFF_FF80},
    '{3'd3, 2'd0, 32'h0000_00FF, 32'h0000_00FF},
    '{3'd2, 2'd1, 32'h0000_ABCD, 32'hFFFF_ABCD},
    '{3'd3, 2'd1, 32'h0000_ABCD, 32'h0000_ABCD},
    '{3'd2, 2'd2, 32'h7F81_2345, 32'hFF81_2345},
    '{3'd3, 2'd2, 32'h7F81_2345, 32'h0081_2345},
    '{3'd3, 2'd3, 32'hDEAD_BEEF, 32'hDEAD_BEEF}
  };

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'h11;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd_ready === 1'b1 && busy === 1'b0, "R1 ready/busy in reset", {30'd0, cmd_ready, busy}, 32'h2);
    chk(rf_we === 1'b0 && addr_we === 1'b0, "R1 strobes in reset", {30'd0, rf_we, addr_we}, 32'h0);
    chk(mem_valid === 1'b0 && pw_ready === 1'b0, "R1 requests in reset", {30'd0, mem_valid, pw_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready === 1'b1 && busy === 1'b0 && !mem_valid, "R1 idle after reset", {31'd0, cmd_ready}, 32'h1);

    // table: loads (R2, R3) and immediates (R4, R5)
    for (int i = 0; i < 15; i++) begin
      vec_t v;
      v = VECS[i];
      for (int k = 0; k < 4; k++) mem[8'h10 + k] = v.src[8*k +: 8];
      run_cmd(v.op, v.wid, 32'h10, 32'h0, v.src, 0, 32'h10);
      if (v.op < 3'd2) begin
        chk(done && n_rf == 1 && got_rf == v.exp, "R2 load value", got_rf, v.exp);
        chk(req_cyc == 1 && !addr_bad, "R3 load request", 32'(req_cyc), 32'd1);
      end else if (v.wid == 2'd0) begin
        chk(done && n_rf == 1 && got_rf == v.exp, "R4 byte immediate", got_rf, v.exp);
      end else begin
        chk(done && n_rf == 1 && got_rf == v.exp && req_cyc == 0, "R5 wide immediate", got_rf, v.exp);
      end
      chk(!dbl && n_ad == 0, "R11 single strobe", 32'(n_ad), 32'd0);
    end

    // R5: gaps in program words keep busy high
    run_cmd(3'd2, 2'd3, 32'h0, 32'h0, 32'h8765_4321, 3, 32'h0);
    chk(gap_busy == 3, "R5 busy during word gap", 32'(gap_busy), 32'd3);
    chk(n_rf == 1 && got_rf == 32'h8765_4321, "R5 gapped immediate value", got_rf, 32'h8765_4321);

    // R6: 16-bit store leaves upper lanes untouched
    for (int k = 0; k < 4; k++) mem[8'h20 + k] = 8'h11;
    run_cmd(3'd4, 2'd1, 32'h20, 32'hCAFE_BABE, 32'h0, 0, 32'h20);
    chk({mem[8'h23], mem[8'h22], mem[8'h21], mem[8'h20]} == 32'h1111_BABE, "R6 store bytes",
        {mem[8'h23], mem[8'h22], mem[8'h21], mem[8'h20]}, 32'h1111_BABE);
    chk(done && n_rf == 0 && n_ad == 0 && req_cyc == 1 && !addr_bad, "R6 store strobes", 32'(n_rf + n_ad), 32'd0);

    // R7: push
    run_cmd(3'd5, 2'd0, 32'h40, 32'h0102_0304, 32'h0, 0, 32'h40);
    chk({mem[8'h43], mem[8'h42], mem[8'h41], mem[8'h40]} == 32'h0102_0304, "R7 push data",
        {mem[8'h43], mem[8'h42], mem[8'h41], mem[8'h40]}, 32'h0102_0304);
    chk(n_ad == 1 && got_ad == 32'h44 && n_rf == 0, "R7 push address", got_ad, 32'h44);

    // R8: pop undoes the push
    run_cmd(3'd6, 2'd0, 32'h44, 32'h0, 32'h0, 0, 32'h40);
    chk(n_rf == 1 && got_rf == 32'h0102_0304, "R8 pop data", got_rf, 32'h0102_0304);
    chk(n_ad == 1 && got_ad == 32'h40 && !addr_bad, "R8 pop address", got_ad, 32'h40);

    // R9, R10: stalled load request
    for (int k = 0; k < 4; k++) mem[8'h30 + k] = 8'h80 + 8'(k);
    stall_left = 3;
    run_cmd(3'd1, 2'd3, 32'h30, 32'h0, 32'h0, 0, 32'h30);
    chk(req_cyc == 4 && !addr_bad, "R9 request held through stall", 32'(req_cyc), 32'd4);
    chk(got_rf == 32'h8382_8180, "R9 stalled load value", got_rf, 32'h8382_8180);
    chk(rdy_stall == 0, "R10 no command during stall", 32'(rdy_stall), 32'd0);

    // R10: stray response while idle
    stray = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rf_we === 1'b0 && cmd_ready === 1'b1, "R10 stray response ignored", {31'd0, rf_we}, 32'd0);
    run_cmd(3'd3, 2'd0, 32'h0, 32'h0, 32'h0000_005A, 0, 32'h0);
    chk(got_rf == 32'h5A && n_rf == 1, "R10 state intact after stray", got_rf, 32'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule